// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block follows the stages of a control transfer on endpoint 0 and reports where the transfer stands as a 3-bit code. A protocol engine feeds it single-cycle pulses: a setup packet has arrived (along with the packet's direction bit and a flag that says whether a data stage follows), an IN token, an OUT token, and a completed handshake. The tracker updates its code on the next clock edge. A register block can read this code directly. The same register block also reads a separate flag that records that a setup packet has arrived.

A setup packet always restarts tracking, whatever the current stage. After that, each token is compared with the direction the current stage expects. A token that fits moves the transfer forward or holds it where it is. A token that does not fit moves the tracker to a sequence-error code. The error code holds until the next setup packet arrives. When the handshake of a status stage completes, the tracker goes back to idle. A parameter chooses what tokens do in the idle stage: either they are ignored, or they are treated as a sequence error.

Top module: `ctl_stage_tracker`

## Requirements
- R1: The stage code takes these values: 000 idle, 001 read data, 010 read status, 011 write data, 100 write status, 101 no-data status, 110 sequence error. The code 111 never appears.
- R2: A setup pulse in any stage sets the code on the next cycle. If `setup_dir_in`=1 and `setup_has_data`=1 the code becomes 001. If `setup_dir_in`=0 and `setup_has_data`=1 it becomes 011. If `setup_has_data`=0 it becomes 101. A setup pulse takes priority over any token or handshake in the same cycle.
- R3: In stage 001, an IN token or a handshake leaves the code at 001, and an OUT token moves it to 010.
- R4: In stage 011, an OUT token or a handshake leaves the code at 011, and an IN token moves it to 100.
- R5: In the status stages the expected token is OUT for 010 and IN for 100 and 101. The expected token keeps the stage unchanged. The opposite token moves the code to 110. A handshake returns the code to 000.
- R6: IN and OUT pulsed together in stage 001 through 101 move the code to 110. When a token and a handshake arrive in the same cycle, the token is acted on and the handshake is ignored.
- R7: Stage 110 holds against tokens and handshakes until a setup pulse arrives. `seq_err` is high exactly when the code is 110.
- R8: In stage 000, handshakes are always ignored. With `IDLE_TOKEN_ERR`=0, tokens are also ignored. With `IDLE_TOKEN_ERR`=1, any token moves the code to 110.
- R9: `setup_valid` goes high on the cycle after a setup pulse. A `setup_ack` pulse clears it. When both arrive in the same cycle, the set wins.
- R10: While `rst_n` is low, the code is 000 and `seq_err` and `setup_valid` are 0. This also holds when reset is applied in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_stb | input | 1 | Pulse: setup packet received |
| setup_dir_in | input | 1 | Direction of the setup packet (1 = device to host) |
| setup_has_data | input | 1 | 1 when the setup packet announces a data stage |
| in_tok | input | 1 | Pulse: IN token on endpoint 0 |
| out_tok | input | 1 | Pulse: OUT token on endpoint 0 |
| hs_done | input | 1 | Pulse: handshake completed |
| setup_ack | input | 1 | Pulse: clears the setup-received flag |
| stage_code | output | 3 | Current stage code |
| seq_err | output | 1 | High while in the sequence-error stage |
| setup_valid | output | 1 | Setup-received flag |

## Verification
The bench builds two copies of the tracker that share the same inputs: one with `IDLE_TOKEN_ERR`=0 and one with `IDLE_TOKEN_ERR`=1. Having both copies makes both idle-token policies observable in the same stimulus run. The tracker drives a vector table through every legal transfer path and every misplaced token. The table also covers a setup that arrives in the middle of a transfer, a setup that coincides with tokens, IN and OUT together, and a token arriving together with a handshake. Directed steps then check the setup flag's set/clear race and reset in the middle of a transfer.

// File: rtl/ctl_stage_pkg.sv
package ctl_stage_pkg;
    localparam int STAGE_W = 3;
    localparam int EVT_W   = 3;

    typedef enum logic [STAGE_W-1:0] {
        STG_IDLE    = 3'b000,
        STG_RD_DATA = 3'b001,
        STG_RD_STAT = 3'b010,
        STG_WR_DATA = 3'b011,
        STG_WR_STAT = 3'b100,
        STG_ND_STAT = 3'b101,
        STG_ERR     = 3'b110
    } stage_e;

    typedef enum logic [EVT_W-1:0] {
        EV_NONE     = 3'd0,
        EV_SETUP_RD = 3'd1,
        EV_SETUP_WR = 3'd2,
        EV_SETUP_ND = 3'd3,
        EV_IN       = 3'd4,
        EV_OUT      = 3'd5,
        EV_CLASH    = 3'd6,
        EV_HS       = 3'd7
    } evt_e;

    typedef struct packed {
        stage_e stage;
        logic   err;
    } fsm_st_t;
endpackage

// File: rtl/ctl_evt_arb.sv
module ctl_evt_arb
    import ctl_stage_pkg::*;
(
    input  logic setup_stb,
    input  logic setup_dir_in,
    input  logic setup_has_data,
    input  logic in_tok,
    input  logic out_tok,
    input  logic hs_done,
    output evt_e evt
);
    // Priority: setup, then token clash, then single token, then handshake.
    always_comb begin
        evt = EV_NONE;
        if (setup_stb) begin
            if (!setup_has_data)   evt = EV_SETUP_ND;
            else if (setup_dir_in) evt = EV_SETUP_RD;
            else                   evt = EV_SETUP_WR;
        end else if (in_tok && out_tok) begin
            evt = EV_CLASH;
        end else if (in_tok) begin
            evt = EV_IN;
        end else if (out_tok) begin
            evt = EV_OUT;
        end else if (hs_done) begin
            evt = EV_HS;
        end
    end
endmodule

// File: rtl/ctl_stage_fsm.sv
module ctl_stage_fsm
    import ctl_stage_pkg::*;
#(
    parameter bit IDLE_TOKEN_ERR = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  evt_e   evt,
    output stage_e stage,
    output logic   seq_err
);
    fsm_st_t st_d, st_q;
    logic    is_token;
    logic    idle_trip;

    assign is_token = (evt == EV_IN) || (evt == EV_OUT) || (evt == EV_CLASH);

    generate
        if (IDLE_TOKEN_ERR) begin : g_idle_strict
            assign idle_trip = is_token;
        end else begin : g_idle_lenient
            assign idle_trip = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        case (evt)
            EV_SETUP_RD: st_d.stage = STG_RD_DATA;
            EV_SETUP_WR: st_d.stage = STG_WR_DATA;
            EV_SETUP_ND: st_d.stage = STG_ND_STAT;
            default: begin
                case (st_q.stage)
                    STG_IDLE: begin
                        if (idle_trip) st_d.stage = STG_ERR;
                    end
                    STG_RD_DATA: begin
                        if (evt == EV_OUT)        st_d.stage = STG_RD_STAT;
                        else if (evt == EV_CLASH) st_d.stage = STG_ERR;
                    end
                    STG_RD_STAT: begin
                        if (evt == EV_IN || evt == EV_CLASH) st_d.stage = STG_ERR;
                        else if (evt == EV_HS)               st_d.stage = STG_IDLE;
                    end
                    STG_WR_DATA: begin
                        if (evt == EV_IN)         st_d.stage = STG_WR_STAT;
                        else if (evt == EV_CLASH) st_d.stage = STG_ERR;
                    end
                    STG_WR_STAT, STG_ND_STAT: begin
                        if (evt == EV_OUT || evt == EV_CLASH) st_d.stage = STG_ERR;
                        else if (evt == EV_HS)                st_d.stage = STG_IDLE;
                    end
                    default: st_d.stage = STG_ERR;
                endcase
            end
        endcase
        st_d.err = (st_d.stage == STG_ERR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stage <= STG_IDLE;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage   = st_q.stage;
    assign seq_err = st_q.err;
endmodule

// File: rtl/ctl_setup_flag.sv
module ctl_setup_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ctl_stage_tracker.sv
module ctl_stage_tracker
    import ctl_stage_pkg::*;
#(
    parameter bit IDLE_TOKEN_ERR = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               setup_stb,
    input  logic               setup_dir_in,
    input  logic               setup_has_data,
    input  logic               in_tok,
    input  logic               out_tok,
    input  logic               hs_done,
    input  logic               setup_ack,
    output logic [STAGE_W-1:0] stage_code,
    output logic               seq_err,
    output logic               setup_valid
);
    evt_e   evt;
    stage_e stage;

    ctl_evt_arb u_arb (
        .setup_stb      (setup_stb),
        .setup_dir_in   (setup_dir_in),
        .setup_has_data (setup_has_data),
        .in_tok         (in_tok),
        .out_tok        (out_tok),
        .hs_done        (hs_done),
        .evt            (evt)
    );

    ctl_stage_fsm #(.IDLE_TOKEN_ERR(IDLE_TOKEN_ERR)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .stage   (stage),
        .seq_err (seq_err)
    );

    ctl_setup_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (setup_stb),
        .clr_i  (setup_ack),
        .flag_o (setup_valid)
    );

    assign stage_code = stage;
endmodule

// File: rtl/ctl_stage_tracker_chk.sv
module ctl_stage_tracker_chk #(
    parameter bit IDLE_TOKEN_ERR = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       setup_stb,
    input logic       setup_dir_in,
    input logic       setup_has_data,
    input logic       in_tok,
    input logic       out_tok,
    input logic       hs_done,
    input logic       setup_ack,
    input logic [2:0] stage_code,
    input logic       seq_err,
    input logic       setup_valid
);
    p_no_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stage_code != 3'b111);

    p_setup_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb |=> stage_code == (!$past(setup_has_data) ? 3'b101 :
                                     ($past(setup_dir_in) ? 3'b001 : 3'b011)));

    p_status_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!setup_stb && !in_tok && !out_tok && hs_done &&
         (stage_code == 3'b010 || stage_code == 3'b100 || stage_code == 3'b101))
        |=> stage_code == 3'b000);

    p_clash_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!setup_stb && in_tok && out_tok && stage_code != 3'b000) |=> stage_code == 3'b110);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_code == 3'b110 && !setup_stb) |=> stage_code == 3'b110);

    p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err == (stage_code == 3'b110));

    generate
        if (IDLE_TOKEN_ERR) begin : g_strict
            p_idle_token_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (stage_code == 3'b000 && !setup_stb && (in_tok || out_tok)) |=> stage_code == 3'b110);
        end else begin : g_lenient
            p_idle_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (stage_code == 3'b000 && !setup_stb) |=> stage_code == 3'b000);
        end
    endgenerate

    p_valid_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb |=> setup_valid);

    p_valid_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_ack && !setup_stb) |=> !setup_valid);
endmodule

bind ctl_stage_tracker ctl_stage_tracker_chk #(.IDLE_TOKEN_ERR(IDLE_TOKEN_ERR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .setup_stb      (setup_stb),
    .setup_dir_in   (setup_dir_in),
    .setup_has_data (setup_has_data),
    .in_tok         (in_tok),
    .out_tok        (out_tok),
    .hs_done        (hs_done),
    .setup_ack      (setup_ack),
    .stage_code     (stage_code),
    .seq_err        (seq_err),
    .setup_valid    (setup_valid)
);

// File: tb/sim_ctl_stage_tracker.sv
`timescale 1ns/1ps
module sim_ctl_stage_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_stb = 0, setup_dir_in = 0, setup_has_data = 0;
    logic in_tok = 0, out_tok = 0, hs_done = 0, setup_ack = 0;
    logic [2:0] stage0, stage1;
    logic err0, err1, valid0, valid1;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ctl_stage_tracker u0 (
        .clk(clk), .rst_n(rst_n), .setup_stb(setup_stb), .setup_dir_in(setup_dir_in),
        .setup_has_data(setup_has_data), .in_tok(in_tok), .out_tok(out_tok),
        .hs_done(hs_done), .setup_ack(setup_ack),
        .stage_code(stage0), .seq_err(err0), .setup_valid(valid0)
    );

    ctl_stage_tracker #(.IDLE_TOKEN_ERR(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .setup_stb(setup_stb), .setup_dir_in(setup_dir_in),
        .setup_has_data(setup_has_data), .in_tok(in_tok), .out_tok(out_tok),
        .hs_done(hs_done), .setup_ack(setup_ack),
        .stage_code(stage1), .seq_err(err1), .setup_valid(valid1)
    );

    // Vector bits: [8] setup [7] dir_in [6] has_data [5] IN [4] OUT [3] handshake [2:0] expected code
    localparam int NV = 40;
    localparam logic [8:0] VEC [NV] = '{
        9'b1_1_1_0_0_0_001, // R2 read setup
        9'b0_0_0_1_0_0_001, // R3 IN holds
        9'b0_0_0_0_0_1_001, // R3 handshake holds
        9'b0_0_0_0_1_0_010, // R3 OUT to status
        9'b0_0_0_0_1_0_010, // R5 expected token holds
        9'b0_0_0_0_0_1_000, // R5 handshake to idle
        9'b1_0_1_0_0_0_011, // R2 write setup
        9'b0_0_0_0_1_0_011, // R4 OUT holds
        9'b0_0_0_1_0_0_100, // R4 IN to status
        9'b0_0_0_0_0_1_000, // R5
        9'b1_0_0_0_0_0_101, // R2 no-data setup
        9'b0_0_0_1_0_0_101, // R5
        9'b0_0_0_0_0_1_000, // R5
        9'b1_1_1_0_0_0_001, // R2
        9'b0_0_0_0_1_0_010, // R3
        9'b0_0_0_1_0_0_110, // R5 wrong token in read status
        9'b0_0_0_0_0_1_110, // R7 holds on handshake
        9'b0_0_0_1_0_0_110, // R7 holds on token
        9'b1_0_1_0_0_0_011, // R7 setup recovers
        9'b0_0_0_1_0_0_100, // R4
        9'b0_0_0_0_1_0_110, // R5 wrong token in write status
        9'b1_1_0_0_0_0_101, // R2 dir ignored without data
        9'b0_0_0_0_1_0_110, // R5 wrong token in no-data status
        9'b1_1_1_0_0_0_001, // R2
        9'b1_0_0_0_0_0_101, // R2 restart mid-transfer
        9'b0_0_0_1_1_0_110, // R6 clash
        9'b1_0_1_0_0_0_011, // R2
        9'b1_1_1_1_1_1_001, // R2 setup beats tokens
        9'b0_0_0_0_0_1_001, // R3
        9'b0_0_0_1_0_0_001, // R3
        9'b0_0_0_0_1_1_010, // R6 token beats handshake
        9'b0_0_0_0_0_1_000, // R5
        9'b0_0_0_1_0_0_000, // R8 idle IN ignored
        9'b0_0_0_0_1_0_000, // R8 idle OUT ignored
        9'b0_0_0_1_1_1_000, // R8 idle clash ignored
        9'b1_0_1_0_0_0_011, // R2
        9'b0_0_0_0_0_1_011, // R4 handshake holds
        9'b0_0_0_1_0_0_100, // R4
        9'b0_0_0_1_0_0_100, // R5
        9'b0_0_0_0_0_1_000  // R1 back to idle
    };

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic pulse(input logic s, input logic d, input logic l,
                         input logic i, input logic o, input logic h, input logic a);
        @(negedge clk);
        setup_stb = s; setup_dir_in = d; setup_has_data = l;
        in_tok = i; out_tok = o; hs_done = h; setup_ack = a;
        @(negedge clk);
        setup_stb = 0; setup_dir_in = 0; setup_has_data = 0;
        in_tok = 0; out_tok = 0; hs_done = 0; setup_ack = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // R10 reset state
        do_reset();
        chk("R10 stage", stage0, 3'b000);
        chk("R10 seq_err", {2'b00, err0}, 3'b000);
        chk("R10 setup_valid", {2'b00, valid0}, 3'b000);
        rst_n = 1;

        // R1 to R8 table walk
        for (int k = 0; k < NV; k++) begin
            pulse(VEC[k][8], VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4], VEC[k][3], 1'b0);
            chk($sformatf("R1 table step %0d code", k), stage0, VEC[k][2:0]);
            chk($sformatf("R7 table step %0d seq_err", k), {2'b00, err0},
                {2'b00, (VEC[k][2:0] == 3'b110)});
        end

        // R9 setup flag set, clear, race
        chk("R9 set after setups", {2'b00, valid0}, 3'b001);
        pulse(0, 0, 0, 0, 0, 0, 1);
        chk("R9 ack clears", {2'b00, valid0}, 3'b000);
        pulse(1, 1, 1, 0, 0, 0, 1);
        chk("R9 set wins over ack", {2'b00, valid0}, 3'b001);
        chk("R2 stage after race", stage0, 3'b001);

        // R10 reset mid-transfer
        do_reset();
        chk("R10 mid-transfer code", stage0, 3'b000);
        chk("R10 mid-transfer valid", {2'b00, valid0}, 3'b000);
        rst_n = 1;

        // R8 strict idle policy on u1
        pulse(0, 0, 0, 0, 0, 1, 0);
        chk("R8 strict handshake ignored", stage1, 3'b000);
        pulse(0, 0, 0, 1, 0, 0, 0);
        chk("R8 strict idle IN errors", stage1, 3'b110);
        chk("R8 strict seq_err", {2'b00, err1}, 3'b001);
        chk("R8 lenient idle IN ignored", stage0, 3'b000);
        pulse(1, 1, 1, 0, 0, 0, 0);
        chk("R7 strict setup recovers", stage1, 3'b001);
        do_reset();
        rst_n = 1;
        pulse(0, 0, 0, 0, 1, 0, 0);
        chk("R8 strict idle OUT errors", stage1, 3'b110);

        finish_run();
    end
endmodule